// File: doc/BRIEF.md
# Iterative CORDIC Sine and Cosine Engine

This block turns a signed whole-degree angle into the cosine and sine of that angle. Both results are signed fixed-point words with 16 fraction bits. The work is done by a circular-rotation CORDIC loop that runs one micro-rotation per clock. Each micro-rotation uses two arithmetic shifts, one constant from a small arctangent table and three add/subtract operations. The loop converges only for angles of roughly ±99.7°. For that reason, an angle beyond ±90° is first moved by 180° toward zero, and both results are negated at the end.

The start vector is preloaded with the inverse of the loop's accumulated gain (about 0.6073), so no multiplier is needed after the loop. The datapath carries extra guard fraction bits inside, and these are rounded away once at the output. Angles enter on a valid/ready input stream and results leave on a valid/ready output stream. The engine holds one operation at a time:

- The input is ready only while the engine is idle.
- A result stays presented, and stable, until the consumer takes it.
- While the consumer holds off, the producer is held off too.

Top module: `cordic_sincos`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An angle is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after acceptance until the result has been taken.
- R3: `out_valid` rises exactly ITERS (16) clock cycles after the accepting edge.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_cos` and `out_sin` hold their values. On the edge where both are 1, the result is taken: `out_valid` falls and `in_ready` returns to 1.
- R5: For angles from -90 to +90 inclusive, `out_cos` and `out_sin` are within 8 LSB of round(65536·cos) and round(65536·sin). The format is signed two's complement, 16 fraction bits, sign-extended to 32 bits.
- R6: For angles from +91 to +180, the engine uses angle−180 and negates both results. The results stay within 8 LSB of the true cosine and sine; at 180 the cosine is close to −65536.
- R7: For angles from −180 to −91, the engine uses angle+180 and negates both results, with the same 8 LSB bound.
- R8: An angle offered on `in_valid` while an operation is in progress has no effect on that operation's result.
- R9: While `out_valid` is 1, the magnitude of each output never exceeds 65536+16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Angle on `in_angle` is offered |
| in_ready | output | 1 | Engine idle and able to take an angle |
| in_angle | input | ANG_W (9) | Signed angle in whole degrees, −180..+180 |
| out_valid | output | 1 | Result presented on `out_cos`/`out_sin` |
| out_ready | input | 1 | Consumer takes the result |
| out_cos | output | DATA_W (32) | Cosine, signed, 16 fraction bits |
| out_sin | output | DATA_W (32) | Sine, signed, 16 fraction bits |

## Verification
Every whole-degree angle from −180 to +180 is run through the engine and compared with a floating-point cosine and sine. This sweep covers the unfolded range, both folded ranges and the fold edges (±90, ±91, ±180, 0), so an error in a fold threshold, a negation or a table constant shows up as a large error at specific angles.

Separate runs do two other things. They hold `out_ready` low for several cycles, to check that the result stays presented. They also keep offering a different angle during the iterations, which tells a correct input gate apart from one that reloads the operands. The latency is counted on every operation.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // residual-angle word: degrees with ZFRAC fraction bits
  localparam int ZW    = 32;
  localparam int ZFRAC = 16;
  // number of table entries available
  localparam int TABLE_DEPTH = 16;
  // inverse of the accumulated pseudo-rotation gain, 30 fraction bits
  localparam longint unsigned INV_GAIN_Q30 = 64'd652032875;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_t;

  // arctan(2^-i) in degrees, scaled by 2^ZFRAC
  function automatic logic signed [ZW-1:0] atan_step(input int i);
    logic signed [ZW-1:0] v;
    case (i)
      0:  v = 32'sd2949120;
      1:  v = 32'sd1740968;
      2:  v = 32'sd919879;
      3:  v = 32'sd466945;
      4:  v = 32'sd234378;
      5:  v = 32'sd117303;
      6:  v = 32'sd58666;
      7:  v = 32'sd29335;
      8:  v = 32'sd14668;
      9:  v = 32'sd7334;
      10: v = 32'sd3667;
      11: v = 32'sd1833;
      12: v = 32'sd917;
      13: v = 32'sd458;
      14: v = 32'sd229;
      15: v = 32'sd115;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold
  import cordic_pkg::*;
#(
  parameter int ANG_W = 9
) (
  input  logic [ANG_W-1:0] angle,
  output logic [ZW-1:0]    z_start,
  output logic             negate
);
  localparam int EW = ANG_W + 1;
  localparam logic signed [EW-1:0] QUARTER = EW'(90);
  localparam logic signed [EW-1:0] HALF    = EW'(180);

  logic signed [EW-1:0] a_ext;
  logic signed [EW-1:0] folded;
  logic signed [ZW-1:0] wide;

  always_comb begin
    a_ext = EW'($signed(angle));
    if (a_ext > QUARTER) begin
      folded = a_ext - HALF;
      negate = 1'b1;
    end else if (a_ext < -QUARTER) begin
      folded = a_ext + HALF;
      negate = 1'b1;
    end else begin
      folded = a_ext;
      negate = 1'b0;
    end
    wide    = ZW'(folded);
    z_start = wide <<< ZFRAC;
  end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int IW    = 36,
  parameter int CNT_W = 4
) (
  input  logic [IW-1:0]    x_in,
  input  logic [IW-1:0]    y_in,
  input  logic [ZW-1:0]    z_in,
  input  logic [CNT_W-1:0] idx,
  output logic [IW-1:0]    x_out,
  output logic [IW-1:0]    y_out,
  output logic [ZW-1:0]    z_out
);
  logic signed [IW-1:0] xs, ys;
  logic signed [ZW-1:0] ang;
  logic                 turn_neg;

  always_comb begin
    // residual below zero: rotate clockwise; zero counts as positive
    turn_neg = z_in[ZW-1];
    xs  = $signed(x_in) >>> idx;
    ys  = $signed(y_in) >>> idx;
    ang = atan_step(int'(idx));
    if (turn_neg) begin
      x_out = x_in + ys;
      y_out = y_in - xs;
      z_out = z_in + ang;
    end else begin
      x_out = x_in - ys;
      y_out = y_in + xs;
      z_out = z_in - ang;
    end
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
  import cordic_pkg::*;
#(
  parameter int ITERS = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ITERS - 1);

  ctrl_state_t state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign load      = in_ready && in_valid;
  assign step      = (state == ST_RUN);
  assign last      = step && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          idx   <= '0;
        end
        ST_RUN: begin
          idx <= idx + 1'b1;
          if (idx == LAST_IDX) state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos
  import cordic_pkg::*;
#(
  parameter int ANG_W  = 9,
  parameter int DATA_W = 32,
  parameter int FRAC   = 16,
  parameter int GUARD  = 4,
  parameter int ITERS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ANG_W-1:0]  in_angle,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_cos,
  output logic [DATA_W-1:0] out_sin
);
  localparam int IW    = DATA_W + GUARD;
  localparam int IFRAC = FRAC + GUARD;
  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam longint unsigned X_RAW =
    (INV_GAIN_Q30 + (64'd1 << (29 - IFRAC))) >> (30 - IFRAC);
  localparam logic [IW-1:0] X_START = IW'(X_RAW);

  logic             load, step, last;
  logic [CNT_W-1:0] idx;
  logic [ZW-1:0]    z_start;
  logic             neg_start;

  logic [IW-1:0] x_q, y_q, x_n, y_n;
  logic [ZW-1:0] z_q, z_n;
  logic          neg_q;
  logic [DATA_W-1:0] cos_rnd, sin_rnd;
  logic [DATA_W-1:0] cos_q, sin_q;

  cordic_ctrl #(.ITERS(ITERS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load), .step(step),
    .last(last), .idx(idx)
  );

  cordic_fold #(.ANG_W(ANG_W)) u_fold (
    .angle(in_angle), .z_start(z_start), .negate(neg_start)
  );

  cordic_stage #(.IW(IW), .CNT_W(CNT_W)) u_stage (
    .x_in(x_q), .y_in(y_q), .z_in(z_q), .idx(idx),
    .x_out(x_n), .y_out(y_n), .z_out(z_n)
  );

  // drop guard bits with round-half-up, or pass straight through
  generate
    if (GUARD > 0) begin : g_round
      logic signed [IW-1:0] xr, yr;
      always_comb begin
        xr = $signed(x_n + IW'(1 << (GUARD - 1))) >>> GUARD;
        yr = $signed(y_n + IW'(1 << (GUARD - 1))) >>> GUARD;
        cos_rnd = xr[DATA_W-1:0];
        sin_rnd = yr[DATA_W-1:0];
      end
    end else begin : g_pass
      assign cos_rnd = x_n[DATA_W-1:0];
      assign sin_rnd = y_n[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      neg_q <= 1'b0;
      cos_q <= '0;
      sin_q <= '0;
    end else begin
      if (load) begin
        x_q   <= X_START;
        y_q   <= '0;
        z_q   <= z_start;
        neg_q <= neg_start;
      end else if (step) begin
        x_q <= x_n;
        y_q <= y_n;
        z_q <= z_n;
      end
      if (last) begin
        cos_q <= neg_q ? -cos_rnd : cos_rnd;
        sin_q <= neg_q ? -sin_rnd : sin_rnd;
      end
    end
  end

  assign out_cos = cos_q;
  assign out_sin = sin_q;

endmodule

// File: rtl/cordic_sincos_chk.sv
module cordic_sincos_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC   = 16,
  parameter int ITERS  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_cos,
  input logic [DATA_W-1:0] out_sin
);
  localparam longint LIM = (64'sd1 <<< FRAC) + 16;

  // cycles since acceptance, frozen once the result is presented
  int unsigned since_acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_acc <= 0;
    else if (in_valid && in_ready) since_acc <= 1;
    else if (since_acc != 0 && !out_valid) since_acc <= since_acc + 1;
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // counter reads ITERS+1 in the first cycle with out_valid high
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (since_acc == ITERS + 1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cos) && $stable(out_sin)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'($signed(out_cos)) <= LIM && longint'($signed(out_cos)) >= -LIM &&
                   longint'($signed(out_sin)) <= LIM && longint'($signed(out_sin)) >= -LIM));

endmodule

bind cordic_sincos cordic_sincos_chk #(.DATA_W(DATA_W), .FRAC(FRAC), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_cos(out_cos), .out_sin(out_sin)
);

// File: tb/cordic_sincos_bench.sv
module cordic_sincos_bench;
  localparam int ANG_W  = 9;
  localparam int DATA_W = 32;
  localparam int ITERS  = 16;
  localparam int TOL    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ANG_W-1:0] in_angle = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DATA_W-1:0] out_cos, out_sin;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cordic_sincos u_cordic_sincos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .out_valid(out_valid), .out_ready(out_ready),
    .out_cos(out_cos), .out_sin(out_sin)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_val(input int deg, input bit want_sin);
    real r, v;
    r = real'(deg) * 3.14159265358979323846 / 180.0;
    v = want_sin ? $sin(r) : $cos(r);
    return int'(v * 65536.0);
  endfunction

  function automatic string range_tag(input int deg);
    if (deg > 90) return "R6";
    if (deg < -90) return "R7";
    return "R5";
  endfunction

  // one full operation; stall = cycles with out_ready low, intr = offer another angle while busy
  task automatic run_op(input int deg, input int stall, input bit intr);
    int lat;
    int c_act, s_act;
    logic [DATA_W-1:0] c_hold, s_hold;
    string tag;
    tag = intr ? "R8" : range_tag(deg);
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before offer", longint'(in_ready), 1);
    in_valid = 1'b1;
    in_angle = ANG_W'(deg);
    @(negedge clk);
    if (intr) in_angle = ANG_W'(deg > 0 ? -45 : 45);
    else in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 busy after accept", longint'(in_ready), 0);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    check(lat == ITERS, "R3 latency", lat, ITERS);
    c_act = $signed(out_cos);
    s_act = $signed(out_sin);
    check((c_act - ref_val(deg, 0)) <= TOL && (ref_val(deg, 0) - c_act) <= TOL,
          {tag, " cos"}, c_act, ref_val(deg, 0));
    check((s_act - ref_val(deg, 1)) <= TOL && (ref_val(deg, 1) - s_act) <= TOL,
          {tag, " sin"}, s_act, ref_val(deg, 1));
    if (c_act > 65536 + 16 || c_act < -65536 - 16 || s_act > 65536 + 16 || s_act < -65536 - 16)
      check(1'b0, "R9 magnitude", c_act, 65536);
    c_hold = out_cos;
    s_hold = out_sin;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && out_cos == c_hold && out_sin == s_hold,
            "R4 hold", longint'($signed(out_cos)), longint'($signed(c_hold)));
      check(in_ready == 1'b0, "R4 no accept while held", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R4 release",
          longint'({out_valid, in_ready}), 1);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 in reset",
          longint'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset",
          longint'({out_valid, in_ready}), 1);
    // full sweep of whole-degree angles
    for (int d = -180; d <= 180; d++) run_op(d, 0, 1'b0);
    // back-pressure on folded and unfolded angles
    run_op(30, 5, 1'b0);
    run_op(-120, 3, 1'b0);
    run_op(180, 2, 1'b0);
    // input offered during iterations must be ignored
    run_op(120, 0, 1'b1);
    run_op(-30, 0, 1'b1);
    run_op(90, 1, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule